// File: doc/BRIEF.md
# Serial Link Start-Up Controller

This block sequences a data-strobe serial link from power-on to full traffic. It owns a six-state, one-hot state vector and moves through it using timed waits and the events reported by the link receiver: NULL, flow-control token (FCT), normal character and time code. It also uses four error flags: parity, escape, disconnect and credit. From the state it drives the receiver's reset and enable. It also tells the transmitter whether it may send nothing, only NULLs, NULLs and FCTs, or every character type.

The wait times are 6.4 us in the error-reset state and 12.8 us in the error-wait, started and connecting states. They are derived from a parameter that gives the system clock in MHz, so the same code serves any clock rate. The receiver reports errors and out-of-order characters before it has decoded its first NULL. These are not trusted and are ignored until that NULL has arrived. Time codes are passed on as a one-cycle tick only while the link is running.

Top module: `linkInitCtrl`

## Requirements
- R1: While reset is high and in the cycle after it drops, the state is ErrorReset (one-hot 6'b000001). In this state `rxReset` is 1, `rxEnable` is 0, all three transmit permissions are 0 and `timeTick` is 0.
- R2: ErrorReset lasts exactly SHORT = ceil(6.4 x CLK_MHZ) clock edges and then becomes ErrorWait (6'b000010). In every state other than ErrorReset, `rxReset` is 0 and `rxEnable` is 1.
- R3: ErrorWait lasts LONG = ceil(12.8 x CLK_MHZ) clock edges from its entry and then becomes Ready (6'b000100). Events that are ignored do not restart this wait.
- R4: Until a NULL has been received since ErrorReset was last left, the following have no effect on the state or on `timeTick`: the parity, escape and disconnect flags, and got-FCT, got-N-char and got-time.
- R5: In ErrorWait, Ready or Started, once a NULL has been received, any of these forces ErrorReset on the next edge: parity, escape or disconnect error, got-FCT, got-N-char or got-time.
- R6: Ready stays put while `linkEnable` is 0 and becomes Started (6'b001000) on the edge after `linkEnable` is 1. Started becomes Connecting (6'b010000) on got-NULL.
- R7: If Started or Connecting lasts LONG edges without its expected event, the state becomes ErrorReset.
- R8: Connecting becomes Run (6'b100000) on got-FCT. A parity, escape or disconnect error, a got-N-char or a got-time in Connecting forces ErrorReset, and any of these wins over a got-FCT in the same cycle.
- R9: In Run, a parity, escape, disconnect or credit error, or `linkEnable` at 0, forces ErrorReset. Got-NULL, got-FCT and got-N-char leave the state in Run.
- R10: `txSendNull` is 1 in Started, Connecting and Run. `txSendFct` is 1 in Connecting and Run. `txSendAll` is 1 only in Run. All three are 0 in the other states.
- R11: `timeTick` is 1 in the cycle after got-time is seen in Run, and 0 otherwise.
- R12: The state vector always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| linkEnable | input | 1 | Link enable / start request |
| gotNull | input | 1 | Receiver decoded a NULL (pulse) |
| gotFct | input | 1 | Receiver decoded an FCT (pulse) |
| gotNchar | input | 1 | Receiver decoded a data or end-of-packet character (pulse) |
| gotTime | input | 1 | Receiver decoded a time code (pulse) |
| errParity | input | 1 | Receiver parity error |
| errEscape | input | 1 | Receiver illegal escape sequence |
| errDisconnect | input | 1 | Receiver saw no line transition for the disconnect window |
| errCredit | input | 1 | Flow-control credit error |
| linkState | output | 6 | One-hot link state |
| rxEnable | output | 1 | Receiver enable |
| rxReset | output | 1 | Receiver held in reset |
| txSendNull | output | 1 | Transmitter may send NULLs |
| txSendFct | output | 1 | Transmitter may send FCTs |
| txSendAll | output | 1 | Transmitter may send all characters |
| timeTick | output | 1 | Forwarded time-code tick |

## Verification
The bench builds the block with CLK_MHZ = 10, so SHORT is 64 edges and LONG is 128 edges. With these values every timed exit can be reached in a few hundred cycles: the ErrorReset and ErrorWait waits and the timeouts in Started and Connecting. Each wait is checked one edge before it expires and again on the edge where it expires. The short waits also make it cheap to walk the link to Run again and again, so that each error source, the event priority in Connecting and the rule that ignores events before the first NULL each get a start-up of their own.

// File: rtl/linkInitPkg.sv
package linkInitPkg;

  typedef enum logic [5:0] {
    ST_ERR_RESET  = 6'b000001,
    ST_ERR_WAIT   = 6'b000010,
    ST_READY      = 6'b000100,
    ST_STARTED    = 6'b001000,
    ST_CONNECTING = 6'b010000,
    ST_RUN        = 6'b100000
  } linkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic restartTimer;
    logic clearNull;
    logic inRun;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic shortDone;
    logic longDone;
    logic nullSeen;
  } dpStatus_t;

  // receiver event bundle
  typedef struct packed {
    logic gotNull;
    logic gotFct;
    logic gotNchar;
    logic gotTime;
  } rxEvent_t;

  // receiver and link error bundle
  typedef struct packed {
    logic parity;
    logic escape;
    logic disconnect;
    logic credit;
  } linkErr_t;

endpackage

// File: rtl/linkInitDatapath.sv
module linkInitDatapath
  import linkInitPkg::*;
#(
  parameter int CLK_MHZ = 250
) (
  input  logic        clk,
  input  logic        rst,
  input  ctrlStrobe_t strobe,
  input  rxEvent_t    rxEv,
  output dpStatus_t   status,
  output logic        timeTick
);

  // 6.4 us and 12.8 us, rounded up to whole clock cycles
  localparam int SHORT_TICKS = (CLK_MHZ * 64 + 9) / 10;
  localparam int LONG_TICKS  = (CLK_MHZ * 128 + 9) / 10;
  localparam int CNT_W       = $clog2(LONG_TICKS + 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_TICKS - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_TICKS - 1);

  logic [CNT_W-1:0] dwellCnt;
  logic             nullSeenQ;
  logic             tickQ;

  // dwell timer, cleared on each state change, saturates at the long limit
  always_ff @(posedge clk) begin
    if (rst || strobe.restartTimer) begin
      dwellCnt <= '0;
    end else if (dwellCnt != LONG_LAST) begin
      dwellCnt <= dwellCnt + 1'b1;
    end
  end

  // first-NULL tracker, cleared while the receiver is held in reset
  always_ff @(posedge clk) begin
    if (rst || strobe.clearNull) begin
      nullSeenQ <= 1'b0;
    end else if (rxEv.gotNull) begin
      nullSeenQ <= 1'b1;
    end
  end

  // time-code forwarding, only while running
  always_ff @(posedge clk) begin
    if (rst) begin
      tickQ <= 1'b0;
    end else begin
      tickQ <= rxEv.gotTime && strobe.inRun;
    end
  end

  assign status.shortDone = (dwellCnt == SHORT_LAST);
  assign status.longDone  = (dwellCnt == LONG_LAST);
  assign status.nullSeen  = nullSeenQ;
  assign timeTick         = tickQ;

endmodule

// File: rtl/linkInitControl.sv
module linkInitControl
  import linkInitPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        linkEnable,
  input  rxEvent_t    rxEv,
  input  linkErr_t    linkErr,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output linkState_e  curState,
  output logic        rxEnable,
  output logic        rxReset,
  output logic        txSendNull,
  output logic        txSendFct,
  output logic        txSendAll
);

  linkState_e stateQ;
  linkState_e stateNext;
  logic       rxFault;
  logic       earlyFault;
  logic       connectFault;
  logic       runFault;

  // receiver faults, trusted only after the first NULL
  assign rxFault      = linkErr.parity || linkErr.escape || linkErr.disconnect;
  assign earlyFault   = status.nullSeen &&
                        (rxFault || rxEv.gotFct || rxEv.gotNchar || rxEv.gotTime);
  assign connectFault = rxFault || rxEv.gotNchar || rxEv.gotTime;
  assign runFault     = rxFault || linkErr.credit || !linkEnable;

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      ST_ERR_RESET: begin
        if (status.shortDone) stateNext = ST_ERR_WAIT;
      end
      ST_ERR_WAIT: begin
        if (earlyFault)            stateNext = ST_ERR_RESET;
        else if (status.longDone)  stateNext = ST_READY;
      end
      ST_READY: begin
        if (earlyFault)            stateNext = ST_ERR_RESET;
        else if (linkEnable)       stateNext = ST_STARTED;
      end
      ST_STARTED: begin
        if (earlyFault)            stateNext = ST_ERR_RESET;
        else if (rxEv.gotNull)     stateNext = ST_CONNECTING;
        else if (status.longDone)  stateNext = ST_ERR_RESET;
      end
      ST_CONNECTING: begin
        if (connectFault)          stateNext = ST_ERR_RESET;
        else if (rxEv.gotFct)      stateNext = ST_RUN;
        else if (status.longDone)  stateNext = ST_ERR_RESET;
      end
      ST_RUN: begin
        if (runFault)              stateNext = ST_ERR_RESET;
      end
      default:                     stateNext = ST_ERR_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_ERR_RESET;
    end else begin
      stateQ <= stateNext;
    end
  end

  assign strobe.restartTimer = (stateNext != stateQ);
  assign strobe.clearNull    = (stateQ == ST_ERR_RESET);
  assign strobe.inRun        = (stateQ == ST_RUN);

  assign curState   = stateQ;
  assign rxReset    = (stateQ == ST_ERR_RESET);
  assign rxEnable   = (stateQ != ST_ERR_RESET);
  assign txSendNull = (stateQ == ST_STARTED) || (stateQ == ST_CONNECTING) || (stateQ == ST_RUN);
  assign txSendFct  = (stateQ == ST_CONNECTING) || (stateQ == ST_RUN);
  assign txSendAll  = (stateQ == ST_RUN);

endmodule

// File: rtl/linkInitCtrl.sv
module linkInitCtrl
  import linkInitPkg::*;
#(
  parameter int CLK_MHZ = 250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       linkEnable,
  input  logic       gotNull,
  input  logic       gotFct,
  input  logic       gotNchar,
  input  logic       gotTime,
  input  logic       errParity,
  input  logic       errEscape,
  input  logic       errDisconnect,
  input  logic       errCredit,
  output logic [5:0] linkState,
  output logic       rxEnable,
  output logic       rxReset,
  output logic       txSendNull,
  output logic       txSendFct,
  output logic       txSendAll,
  output logic       timeTick
);

  rxEvent_t    rxEv;
  linkErr_t    linkErr;
  ctrlStrobe_t strobe;
  dpStatus_t   status;
  linkState_e  curState;

  assign rxEv    = '{gotNull: gotNull, gotFct: gotFct, gotNchar: gotNchar, gotTime: gotTime};
  assign linkErr = '{parity: errParity, escape: errEscape,
                     disconnect: errDisconnect, credit: errCredit};

  linkInitControl uCtrl (
    .clk        (clk),
    .rst        (rst),
    .linkEnable (linkEnable),
    .rxEv       (rxEv),
    .linkErr    (linkErr),
    .status     (status),
    .strobe     (strobe),
    .curState   (curState),
    .rxEnable   (rxEnable),
    .rxReset    (rxReset),
    .txSendNull (txSendNull),
    .txSendFct  (txSendFct),
    .txSendAll  (txSendAll)
  );

  linkInitDatapath #(.CLK_MHZ(CLK_MHZ)) uDp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .rxEv     (rxEv),
    .status   (status),
    .timeTick (timeTick)
  );

  assign linkState = curState;

endmodule

// File: rtl/linkInitChecker.sv
module linkInitChecker (
  input logic       clk,
  input logic       rst,
  input logic       linkEnable,
  input logic       gotFct,
  input logic       gotTime,
  input logic       errCredit,
  input logic [5:0] linkState,
  input logic       timeTick
);

  // R12: state vector stays one-hot
  a_r12_one_hot: assert property (@(posedge clk) disable iff (rst)
    $countones(linkState) == 1);

  // R2: ErrorWait is only entered from ErrorReset
  a_r2_wait_after_reset: assert property (@(posedge clk) disable iff (rst)
    $rose(linkState[1]) |-> $past(linkState[0]));

  // R6: Started is only entered from Ready with the link enabled
  a_r6_start_from_ready: assert property (@(posedge clk) disable iff (rst)
    $rose(linkState[3]) |-> ($past(linkState[2]) && $past(linkEnable)));

  // R8: Run is only entered from Connecting on an FCT
  a_r8_run_from_connecting: assert property (@(posedge clk) disable iff (rst)
    $rose(linkState[5]) |-> ($past(linkState[4]) && $past(gotFct)));

  // R9: a credit error in Run drops the link
  a_r9_credit_drops_run: assert property (@(posedge clk) disable iff (rst)
    (linkState[5] && errCredit) |=> linkState[0]);

  // R11: a tick follows a time code seen in Run
  a_r11_tick_only_run: assert property (@(posedge clk) disable iff (rst)
    timeTick |-> ($past(gotTime) && $past(linkState[5])));

endmodule

bind linkInitCtrl linkInitChecker uChk (
  .clk        (clk),
  .rst        (rst),
  .linkEnable (linkEnable),
  .gotFct     (gotFct),
  .gotTime    (gotTime),
  .errCredit  (errCredit),
  .linkState  (linkState),
  .timeTick   (timeTick)
);

// File: tb/tb_linkInitCtrl.sv
`timescale 1ns/1ps
module tb_linkInitCtrl;

  localparam int TB_MHZ = 10;
  localparam int SHORT  = TB_MHZ * 64 / 10;   // 64 edges
  localparam int LONG   = TB_MHZ * 128 / 10;  // 128 edges

  localparam logic [5:0] S_ERST = 6'b000001;
  localparam logic [5:0] S_EWT  = 6'b000010;
  localparam logic [5:0] S_RDY  = 6'b000100;
  localparam logic [5:0] S_STR  = 6'b001000;
  localparam logic [5:0] S_CON  = 6'b010000;
  localparam logic [5:0] S_RUN  = 6'b100000;

  // pulse mask bits
  localparam logic [7:0] P_NULL = 8'h01, P_FCT = 8'h02, P_NCH = 8'h04, P_TIME = 8'h08,
                         P_PAR = 8'h10, P_ESC = 8'h20, P_DSC = 8'h40, P_CRD = 8'h80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic linkEnable = 1'b0;
  logic gotNull = 1'b0, gotFct = 1'b0, gotNchar = 1'b0, gotTime = 1'b0;
  logic errParity = 1'b0, errEscape = 1'b0, errDisconnect = 1'b0, errCredit = 1'b0;
  logic [5:0] linkState;
  logic rxEnable, rxReset, txSendNull, txSendFct, txSendAll, timeTick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  linkInitCtrl #(.CLK_MHZ(TB_MHZ)) dut (
    .clk(clk), .rst(rst), .linkEnable(linkEnable),
    .gotNull(gotNull), .gotFct(gotFct), .gotNchar(gotNchar), .gotTime(gotTime),
    .errParity(errParity), .errEscape(errEscape), .errDisconnect(errDisconnect),
    .errCredit(errCredit), .linkState(linkState), .rxEnable(rxEnable), .rxReset(rxReset),
    .txSendNull(txSendNull), .txSendFct(txSendFct), .txSendAll(txSendAll),
    .timeTick(timeTick)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic checkState(input string tag, input logic [5:0] exp);
    check(tag, {26'd0, linkState}, {26'd0, exp});
    check("R12 one-hot", $countones(linkState), 1);
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] m);
    {errCredit, errDisconnect, errEscape, errParity, gotTime, gotNchar, gotFct, gotNull} = m;
    @(negedge clk);
    {errCredit, errDisconnect, errEscape, errParity, gotTime, gotNchar, gotFct, gotNull} = '0;
  endtask

  task automatic doReset();
    linkEnable = 1'b0;
    rst = 1'b1;
    waitEdges(2);
    checkState("R1 state in reset", S_ERST);
    rst = 1'b0;
    waitEdges(1);
    checkState("R1 state after reset", S_ERST);
    check("R1 rxReset", rxReset, 1);
    check("R1 rxEnable", rxEnable, 0);
    check("R1 tx permissions", {txSendNull, txSendFct, txSendAll}, 0);
    check("R1 timeTick", timeTick, 0);
  endtask

  // reset released one edge before this returns; ErrorWait after SHORT edges total
  task automatic toErrorWait();
    doReset();
    waitEdges(SHORT - 1);
    checkState("R2 ErrorWait entry", S_EWT);
  endtask

  task automatic toReady();
    toErrorWait();
    waitEdges(LONG);
    checkState("R3 Ready entry", S_RDY);
  endtask

  task automatic toConnecting();
    toReady();
    linkEnable = 1'b1;
    waitEdges(1);
    checkState("R6 Started", S_STR);
    pulse(P_NULL);
    checkState("R6 Connecting", S_CON);
  endtask

  task automatic toRun();
    toConnecting();
    pulse(P_FCT);
    checkState("R8 Run", S_RUN);
  endtask

  task automatic testResetDwell();
    doReset();
    waitEdges(SHORT - 2);
    checkState("R2 still ErrorReset", S_ERST);
    waitEdges(1);
    checkState("R2 ErrorWait after SHORT", S_EWT);
    check("R2 rxReset low", rxReset, 0);
    check("R2 rxEnable high", rxEnable, 1);
  endtask

  task automatic testIgnoredBeforeNull();
    toErrorWait();
    pulse(P_PAR);
    pulse(P_FCT | P_NCH);
    pulse(P_TIME | P_ESC | P_DSC);
    checkState("R4 events ignored before NULL", S_EWT);
    check("R4 no tick outside Run", timeTick, 0);
    waitEdges(LONG - 4);
    checkState("R3 ErrorWait one edge early", S_EWT);
    waitEdges(1);
    checkState("R3 Ready after LONG", S_RDY);
    check("R10 no tx in Ready", {txSendNull, txSendFct, txSendAll}, 0);
  endtask

  task automatic testWaitError();
    toErrorWait();
    pulse(P_NULL);
    checkState("R5 NULL keeps ErrorWait", S_EWT);
    pulse(P_ESC);
    checkState("R5 escape in ErrorWait", S_ERST);
    toErrorWait();
    pulse(P_NULL);
    pulse(P_FCT);
    checkState("R5 FCT in ErrorWait", S_ERST);
  endtask

  task automatic testReadyError();
    toReady();
    waitEdges(5);
    checkState("R6 Ready holds while disabled", S_RDY);
    pulse(P_NULL);
    checkState("R5 NULL keeps Ready", S_RDY);
    pulse(P_DSC);
    checkState("R5 disconnect in Ready", S_ERST);
  endtask

  task automatic testStartedTimeout();
    toReady();
    linkEnable = 1'b1;
    waitEdges(1);
    checkState("R6 Started on enable", S_STR);
    check("R10 Started tx", {txSendNull, txSendFct, txSendAll}, 3'b100);
    waitEdges(LONG - 1);
    checkState("R7 Started one edge early", S_STR);
    waitEdges(1);
    checkState("R7 Started timeout", S_ERST);
    linkEnable = 1'b0;
  endtask

  task automatic testConnectingTimeout();
    toConnecting();
    check("R10 Connecting tx", {txSendNull, txSendFct, txSendAll}, 3'b110);
    waitEdges(LONG - 1);
    checkState("R7 Connecting one edge early", S_CON);
    waitEdges(1);
    checkState("R7 Connecting timeout", S_ERST);
    linkEnable = 1'b0;
  endtask

  task automatic testConnectPriority();
    toConnecting();
    pulse(P_FCT | P_PAR);
    checkState("R8 error beats FCT", S_ERST);
    toConnecting();
    pulse(P_NCH);
    checkState("R8 N-char in Connecting", S_ERST);
    linkEnable = 1'b0;
  endtask

  task automatic testRun();
    toRun();
    check("R10 Run tx", {txSendNull, txSendFct, txSendAll}, 3'b111);
    pulse(P_NULL | P_NCH);
    pulse(P_FCT);
    checkState("R9 normal traffic stays Run", S_RUN);
    pulse(P_TIME);
    check("R11 tick in Run", timeTick, 1);
    checkState("R11 time keeps Run", S_RUN);
    waitEdges(1);
    check("R11 tick one cycle", timeTick, 0);
    pulse(P_CRD);
    checkState("R9 credit error", S_ERST);
    check("R11 no tick after Run", timeTick, 0);
    toRun();
    linkEnable = 1'b0;
    waitEdges(1);
    checkState("R9 link disable", S_ERST);
    toRun();
    pulse(P_DSC);
    checkState("R9 disconnect in Run", S_ERST);
    linkEnable = 1'b0;
  endtask

  initial begin
    testResetDwell();
    testIgnoredBeforeNull();
    testWaitError();
    testReadyError();
    testStartedTimeout();
    testConnectingTimeout();
    testConnectPriority();
    testRun();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule